// File: doc/BRIEF.md
# Set-on-less-than compare unit

This unit produces the 0/1 result of a "set if less than" instruction in a 32-bit datapath. The instruction decoder supplies two register operands, the instruction word and two control bits. One bit picks the register form or the immediate form. The other bit picks signed or unsigned comparison. The unit places the result in bit 0 of a 32-bit word and picks the destination register index from the instruction field that the chosen form writes.

Every kind of compare goes through one magnitude comparator. Flipping the top bit of both operands turns a two's-complement order into an unsigned order, so the signed and unsigned compares share the same hardware. A single bit pattern can therefore give opposite answers under the two modes. One example is all-ones against one.

The result, the destination index and a valid flag are registered. They appear on the clock edge that follows an input strobe and then hold until the next strobe.

Top module: `slt_unit`

## Requirements
- R1: With `is_unsigned` = 0, the compare treats both operands as two's-complement values. `out_result` is 1 when the first is smaller, so all-ones against 1 gives 1 and 0x80000000 against 0x7FFFFFFF gives 1.
- R2: With `is_unsigned` = 1, the compare treats both operands as unsigned magnitudes. All-ones against 1 gives 0 and 0x80000000 against 0x7FFFFFFF gives 0.
- R3: With `use_imm` = 1, the second operand is `instr[15:0]` sign-extended to 32 bits under either signedness, and `src_b` has no effect. Immediate 0xFFFF under unsigned comparison therefore acts as 0xFFFFFFFF.
- R4: The register form (`use_imm` = 0) drives `out_dest` from `instr[15:11]`. The immediate form drives it from `instr[20:16]`.
- R5: Bits 31..1 of `out_result` are always 0.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result and index of that strobe appear on that same edge, including when strobes come back to back.
- R7: Without a strobe, `out_result` and `out_dest` keep their previous values and `out_valid` is low.
- R8: While `rst` is high, at the next clock edge `out_valid`, `out_result` and `out_dest` become 0.
- R9: Equal operands give 0 in every form and under either signedness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: the inputs hold an operation this cycle |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand for the register form |
| instr | input | 32 | Instruction word: immediate [15:0], rd [15:11], rt [20:16] |
| use_imm | input | 1 | 1 = immediate form, 0 = register form |
| is_unsigned | input | 1 | 1 = unsigned compare, 0 = signed compare |
| out_valid | output | 1 | Registered strobe |
| out_result | output | 32 | 0 or 1 compare result |
| out_dest | output | 5 | Destination register index |

## Verification
The assertions assume that `in_valid`, `use_imm`, `is_unsigned`, the operands and `instr` carry known values on every clock edge after reset. They also assume that the inputs of a strobe cycle are the ones meant for the result of the next cycle, since they sample those inputs through `$past`. The bench drives every input to a defined value at the falling edge and never leaves one unknown. It changes the operands and the instruction during idle cycles on purpose, so the hold behaviour is checked against data that really moves.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic {
    FORM_REG = 1'b0,
    FORM_IMM = 1'b1
  } slt_form_e;

  typedef enum logic {
    ORDER_SIGNED   = 1'b0,
    ORDER_UNSIGNED = 1'b1
  } slt_order_e;

  localparam int CMP_BUILTIN = 0;
  localparam int CMP_BORROW  = 1;
endpackage

// File: rtl/slt_operand_sel.sv
module slt_operand_sel #(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 16,
  parameter int IDX_W   = 5,
  parameter int RD_LSB  = 11,
  parameter int RT_LSB  = 16
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src_b,
  input  slt_pkg::slt_form_e form,
  output logic [DATA_W-1:0]  b_eff,
  output logic [IDX_W-1:0]   dest_idx
);
  localparam int EXT_W  = DATA_W - IMM_W;
  localparam int USED_W = RT_LSB + IDX_W;

  logic [IMM_W-1:0] imm_field;
  logic [DATA_W-1:0] imm_ext;
  logic [INSTR_W-USED_W-1:0] unused_instr_hi;

  assign imm_field       = instr[IMM_W-1:0];
  assign imm_ext         = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};
  assign unused_instr_hi = instr[INSTR_W-1:USED_W];

  always_comb begin
    if (form == slt_pkg::FORM_IMM) begin
      b_eff    = imm_ext;
      dest_idx = instr[RT_LSB +: IDX_W];
    end else begin
      b_eff    = src_b;
      dest_idx = instr[RD_LSB +: IDX_W];
    end
  end
endmodule

// File: rtl/slt_comparator.sv
module slt_comparator #(
  parameter int DATA_W = 32,
  parameter int IMPL   = slt_pkg::CMP_BORROW
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  slt_pkg::slt_order_e order,
  output logic                lt
);
  logic flip;
  logic [DATA_W-1:0] a_biased;
  logic [DATA_W-1:0] b_biased;

  assign flip     = (order == slt_pkg::ORDER_SIGNED);
  assign a_biased = {a[DATA_W-1] ^ flip, a[DATA_W-2:0]};
  assign b_biased = {b[DATA_W-1] ^ flip, b[DATA_W-2:0]};

  generate
    if (IMPL == slt_pkg::CMP_BORROW) begin : g_borrow
      logic [DATA_W:0] diff;
      logic [DATA_W-1:0] unused_diff_low;
      assign diff            = {1'b0, a_biased} - {1'b0, b_biased};
      assign unused_diff_low = diff[DATA_W-1:0];
      assign lt              = diff[DATA_W];
    end else begin : g_builtin
      assign lt = (a_biased < b_biased);
    end
  endgenerate
endmodule

// File: rtl/slt_out_reg.sv
module slt_out_reg #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              lt,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              valid_q,
  output logic [DATA_W-1:0] result_q,
  output logic [IDX_W-1:0]  dest_q
);
  logic lt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      lt_q    <= 1'b0;
      dest_q  <= '0;
    end else begin
      valid_q <= strobe;
      if (strobe) begin
        lt_q   <= lt;
        dest_q <= dest_idx;
      end
    end
  end

  assign result_q = {{(DATA_W-1){1'b0}}, lt_q};
endmodule

// File: rtl/slt_unit.sv
module slt_unit #(
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int IMM_W    = 16,
  parameter int IDX_W    = 5,
  parameter int RD_LSB   = 11,
  parameter int RT_LSB   = 16,
  parameter int CMP_IMPL = slt_pkg::CMP_BORROW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [INSTR_W-1:0] instr,
  input  logic               use_imm,
  input  logic               is_unsigned,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_result,
  output logic [IDX_W-1:0]   out_dest
);
  slt_pkg::slt_form_e  form;
  slt_pkg::slt_order_e order;
  logic [DATA_W-1:0] b_eff;
  logic [IDX_W-1:0]  dest_idx;
  logic              lt;

  assign form  = use_imm ? slt_pkg::FORM_IMM : slt_pkg::FORM_REG;
  assign order = is_unsigned ? slt_pkg::ORDER_UNSIGNED : slt_pkg::ORDER_SIGNED;

  slt_operand_sel #(
    .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W),
    .IDX_W(IDX_W), .RD_LSB(RD_LSB), .RT_LSB(RT_LSB)
  ) u_sel (
    .instr(instr), .src_b(src_b), .form(form),
    .b_eff(b_eff), .dest_idx(dest_idx)
  );

  slt_comparator #(.DATA_W(DATA_W), .IMPL(CMP_IMPL)) u_cmp (
    .a(src_a), .b(b_eff), .order(order), .lt(lt)
  );

  slt_out_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .strobe(in_valid), .lt(lt), .dest_idx(dest_idx),
    .valid_q(out_valid), .result_q(out_result), .dest_q(out_dest)
  );
endmodule

// File: rtl/slt_unit_chk.sv
module slt_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 16,
  parameter int IDX_W   = 5,
  parameter int RD_LSB  = 11,
  parameter int RT_LSB  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  src_a,
  input logic [DATA_W-1:0]  src_b,
  input logic [INSTR_W-1:0] instr,
  input logic               use_imm,
  input logic               is_unsigned,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_result,
  input logic [IDX_W-1:0]   out_dest
);
  logic [DATA_W-1:0] ref_b;
  logic              ref_lt;
  logic [IDX_W-1:0]  ref_dest;
  logic [INSTR_W-1:0] unused_instr_copy;

  assign unused_instr_copy = instr;
  assign ref_b = use_imm ? DATA_W'($signed(instr[IMM_W-1:0])) : src_b;
  assign ref_lt = is_unsigned ? (src_a < ref_b) : ($signed(src_a) < $signed(ref_b));
  assign ref_dest = use_imm ? instr[RT_LSB +: IDX_W] : instr[RD_LSB +: IDX_W];

  assert_compare_R1_R2_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result[0] == $past(ref_lt));

  assert_dest_field_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_dest == $past(ref_dest));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_result[DATA_W-1:1] == '0);

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_dest)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && out_dest == '0));
endmodule

bind slt_unit slt_unit_chk #(
  .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W),
  .IDX_W(IDX_W), .RD_LSB(RD_LSB), .RT_LSB(RT_LSB)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
  .instr(instr), .use_imm(use_imm), .is_unsigned(is_unsigned),
  .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest)
);

// File: tb/slt_unit_test.sv
`timescale 1ns/1ps
module slt_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] instr = '0;
  logic        use_imm = 1'b0;
  logic        is_unsigned = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_dest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slt_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .instr(instr), .use_imm(use_imm), .is_unsigned(is_unsigned),
    .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic [4:0] rt, input logic [4:0] rd,
                                           input logic [15:0] imm);
    mk_instr = {6'h0a, 5'h03, rt, 16'h0};
    if (imm != 16'h0) mk_instr[15:0] = imm;
    else mk_instr[15:11] = rd;
  endfunction

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] ins, input logic imm, input logic uns);
    logic [31:0] bb;
    bb = imm ? {{16{ins[15]}}, ins[15:0]} : b;
    if (uns) ref_res = {31'b0, a < bb};
    else     ref_res = {31'b0, $signed(a) < $signed(bb)};
  endfunction

  // Strobe one operation, check it on the following falling edge.
  task automatic op(input string req, input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] ins, input logic imm, input logic uns,
                    input logic [31:0] exp_res);
    @(negedge clk);
    src_a = a; src_b = b; instr = ins; use_imm = imm; is_unsigned = uns; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid R6"}, {31'b0, out_valid}, 32'd1);
    chk({req, " result"}, out_result, exp_res);
    chk({req, " dest R4"}, {27'b0, out_dest}, {27'b0, imm ? ins[20:16] : ins[15:11]});
  endtask

  task automatic t_reset_R8();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 valid", {31'b0, out_valid}, 32'd0);
    chk("R8 result", out_result, 32'd0);
    chk("R8 dest", {27'b0, out_dest}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_sign_flip_R1_R2();
    op("R1 -1<1 signed", 32'hFFFF_FFFF, 32'd1, mk_instr(5'd2, 5'd9, 16'h0), 1'b0, 1'b0, 32'd1);
    op("R2 -1<1 unsigned", 32'hFFFF_FFFF, 32'd1, mk_instr(5'd2, 5'd9, 16'h0), 1'b0, 1'b1, 32'd0);
    op("R1 min<max signed", 32'h8000_0000, 32'h7FFF_FFFF, mk_instr(5'd1, 5'd4, 16'h0), 1'b0, 1'b0, 32'd1);
    op("R2 min<max unsigned", 32'h8000_0000, 32'h7FFF_FFFF, mk_instr(5'd1, 5'd4, 16'h0), 1'b0, 1'b1, 32'd0);
    op("R1 max<min signed", 32'h7FFF_FFFF, 32'h8000_0000, mk_instr(5'd1, 5'd4, 16'h0), 1'b0, 1'b0, 32'd0);
    op("R2 max<min unsigned", 32'h7FFF_FFFF, 32'h8000_0000, mk_instr(5'd1, 5'd4, 16'h0), 1'b0, 1'b1, 32'd1);
  endtask

  task automatic t_equal_R9();
    op("R9 eq signed", 32'h1234_5678, 32'h1234_5678, mk_instr(5'd6, 5'd7, 16'h0), 1'b0, 1'b0, 32'd0);
    op("R9 eq unsigned", 32'hFFFF_FFFF, 32'hFFFF_FFFF, mk_instr(5'd6, 5'd7, 16'h0), 1'b0, 1'b1, 32'd0);
    op("R9 eq imm", 32'hFFFF_FFFF, 32'h0, mk_instr(5'd6, 5'd0, 16'hFFFF), 1'b1, 1'b1, 32'd0);
  endtask

  task automatic t_immediate_R3();
    // src_b chosen to give the opposite answer if it were used
    op("R3 5<0xFFFF unsigned", 32'd5, 32'd0, mk_instr(5'd19, 5'd0, 16'hFFFF), 1'b1, 1'b1, 32'd1);
    op("R3 0<-1 signed", 32'd0, 32'd100, mk_instr(5'd19, 5'd0, 16'hFFFF), 1'b1, 1'b0, 32'd0);
    op("R3 min<-1 signed", 32'h8000_0000, 32'h8000_0000, mk_instr(5'd8, 5'd0, 16'hFFFF), 1'b1, 1'b0, 32'd1);
    op("R3 3<16 signed", 32'd3, 32'd0, mk_instr(5'd8, 5'd0, 16'h0010), 1'b1, 1'b0, 32'd1);
    op("R3 0x8000 unsigned", 32'h7FFF_FFFF, 32'h0, mk_instr(5'd8, 5'd0, 16'h8000), 1'b1, 1'b1, 32'd1);
  endtask

  task automatic t_dest_R4();
    op("R4 reg form rd", 32'd1, 32'd2, {6'h0, 5'd3, 5'd19, 5'd7, 11'h0}, 1'b0, 1'b0, 32'd1);
    op("R4 imm form rt", 32'd1, 32'd0, {6'h0, 5'd3, 5'd19, 16'h3802}, 1'b1, 1'b0, 32'd1);
  endtask

  task automatic t_hold_R7();
    logic [31:0] r0;
    logic [4:0]  d0;
    op("R7 setup", 32'd1, 32'd9, mk_instr(5'd0, 5'd12, 16'h0), 1'b0, 1'b1, 32'd1);
    r0 = out_result; d0 = out_dest;
    src_a = 32'hFFFF_FFFF; src_b = 32'd0; instr = 32'hFFFF_FFFF; use_imm = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 valid low", {31'b0, out_valid}, 32'd0);
    chk("R7 result hold", out_result, r0);
    chk("R7 dest hold", {27'b0, out_dest}, {27'b0, d0});
  endtask

  task automatic t_back_to_back_R6();
    @(negedge clk);
    src_a = 32'd1; src_b = 32'd2; instr = mk_instr(5'd0, 5'd21, 16'h0);
    use_imm = 1'b0; is_unsigned = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R6 b2b first valid", {31'b0, out_valid}, 32'd1);
    chk("R6 b2b first result", out_result, 32'd1);
    chk("R6 b2b first dest", {27'b0, out_dest}, 32'd21);
    src_a = 32'd2; src_b = 32'd1; instr = mk_instr(5'd0, 5'd22, 16'h0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 b2b second valid", {31'b0, out_valid}, 32'd1);
    chk("R6 b2b second result", out_result, 32'd0);
    chk("R6 b2b second dest", {27'b0, out_dest}, 32'd22);
    @(negedge clk);
    chk("R6 valid drops", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_sweep_R5();
    logic [31:0] s;
    s = 32'hACE1_1234;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b, ins;
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      a = s;
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      b = s ^ 32'h5A5A_0F0F;
      ins = {s[7:0], a[23:0]};
      op("R5 sweep", a, b, ins, i[0], i[1], ref_res(a, b, ins, i[0], i[1]));
      chk("R5 upper zero", {1'b0, out_result[31:1]}, 32'd0);
    end
  endtask

  task automatic t_mid_reset_R8();
    @(negedge clk);
    src_a = 32'd0; src_b = 32'd5; instr = mk_instr(5'd0, 5'd30, 16'h0);
    use_imm = 1'b0; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 mid valid", {31'b0, out_valid}, 32'd0);
    chk("R8 mid result", out_result, 32'd0);
    chk("R8 mid dest", {27'b0, out_dest}, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset_R8();
    t_sign_flip_R1_R2();
    t_equal_R9();
    t_immediate_R3();
    t_dest_R4();
    t_hold_R7();
    t_back_to_back_R6();
    t_sweep_R5();
    t_mid_reset_R8();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule